// File: doc/BRIEF.md
# SDRAM Dynamic Power-Down Controller

This block sits beside the command sequencer of an SDRAM controller and decides, cycle by cycle, whether the memory clock-enable (CKE) is held high and whether the external memory clock is allowed to run. When the memory interface has nothing in flight, it drops CKE to power the device down. It can also stop the external clock. Each of these two savings has its own configuration enable, so they can be used separately or together. When a new request arrives during power-down, the block holds that request with a stall signal until the memory may be used again. It then restores CKE and the clock.

How long the stall lasts depends on the memory type. In SDR mode the request proceeds in the cycle right after power-down is left. In DDR mode the request is held for a further programmable number of cycles. A down-counter times this wait. It is loaded when power-down is left and releases the request when it reaches zero. The external-clock-disable setting may only take effect while the interface is idle. A change made while the interface is busy is therefore kept pending in a shadow register and applied on the first idle cycle.

The controller is a three-state machine:
- `ST_ACTIVE`: normal operation.
- `ST_PWRDN`: idle power-down.
- `ST_WAKE`: DDR wake delay.

Its transitions are:
- `ACTIVE->PWRDN` (enter): the interface is idle, no request is present, and at least one saving is enabled.
- `PWRDN->WAKE` (ddr_wake): a request arrives in DDR mode with a nonzero wake latency.
- `PWRDN->ACTIVE` (fast_exit): a request arrives in SDR mode or with a zero latency, or the interface turns busy, or both enables are cleared.
- `WAKE->ACTIVE` (release): the wake counter reaches zero.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: During and right after reset the block is in the active state: `cke`=1, `ext_clk_en`=1, `req_stall`=0.
- R2: With `cfg_pd_en`=1, one cycle with `if_busy`=0 and `req_valid`=0 makes `cke` 0 from the next cycle. `cke` stays 0 for as long as the interface stays idle.
- R3: With `cfg_pd_en`=1 and the applied clock-disable setting 0, `ext_clk_en` stays 1 throughout power-down.
- R4: With the applied clock-disable setting 1, `ext_clk_en` is 0 throughout power-down. In that case `cke` is 0 only if `cfg_pd_en`=1.
- R5: With `cfg_pd_en`=0 and the clock-disable setting 0, `cke` and `ext_clk_en` stay 1 and `req_stall` stays 0 under any traffic.
- R6: While `if_busy`=1 no power-down is entered. If `if_busy` rises during power-down, the next cycle is active, with `cke`=1 and `ext_clk_en`=1.
- R7: In SDR mode (`mode_ddr`=0), a request seen during power-down is stalled for that one cycle only. In the next cycle `cke`=1, `ext_clk_en`=1 and `req_stall`=0.
- R8: In DDR mode (`mode_ddr`=1), a request seen during power-down is stalled in that cycle and for `wake_lat` further cycles, with `cke`=1 and `ext_clk_en`=1 during those further cycles. A `wake_lat` of 0 behaves as in SDR mode.
- R9: `cfg_clk_off` is applied only in a cycle with `if_busy`=0. A value present only while busy has no effect, and the value present on the first idle cycle governs the power-down that follows.
- R10: In the active state `req_stall` is 0, so the power-down mode adds no latency to accesses that find the memory awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pd_en | input | 1 | Enable CKE power-down on idle |
| cfg_clk_off | input | 1 | Request to stop the external clock on idle (applied only when idle) |
| mode_ddr | input | 1 | 0 = SDR memory, 1 = DDR memory |
| req_valid | input | 1 | A new access request is present |
| if_busy | input | 1 | An access is in progress on the memory interface |
| wake_lat | input | WAKE_W | DDR wake delay in cycles |
| cke | output | 1 | SDRAM clock enable |
| ext_clk_en | output | 1 | Enable for the external clock gate |
| req_stall | output | 1 | Hold the incoming request |

## Verification
All three outputs are decoded combinationally from the state register and the current inputs. A stall is therefore visible in the same cycle as the request that causes it. Power-down entry and the restoring of CKE and the clock are due in the cycle after the triggering clock edge, and the DDR release is due `wake_lat` cycles after that. The bench drives inputs on the falling edge and compares all three outputs 1 ns later, once per cycle. Its expected triple for each cycle is derived from the configuration and the cycle's position in the idle, request and wake sequence. It sweeps every combination of the two enables and the mode with wake latencies 0 to 4, and then runs directed sequences for a busy interrupt and for a clock-disable change made while busy.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_PWRDN  = 2'd1,
        ST_WAKE   = 2'd2
    } pd_state_e;

    typedef struct packed {
        logic cke;
        logic clk_en;
        logic stall;
    } pd_out_t;

endpackage

// File: rtl/sdram_pd_cfg_shadow.sv
module sdram_pd_cfg_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic if_busy,
    input  logic clk_off_in,
    output logic clk_off_q,
    output logic clk_off_nxt
);
    // The clock-disable setting only moves while the interface is idle.
    always_comb begin
        clk_off_nxt = if_busy ? clk_off_q : clk_off_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_off_q <= 1'b0;
        end else begin
            clk_off_q <= clk_off_nxt;
        end
    end
endmodule

// File: rtl/sdram_pd_wake_cnt.sv
module sdram_pd_wake_cnt #(
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAKE_W-1:0] load_val,
    input  logic              run,
    output logic              last
);
    localparam logic [WAKE_W-1:0] ONE = WAKE_W'(1);

    logic [WAKE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // True in the cycle whose edge brings the count to zero.
    assign last = (cnt_q <= ONE);
endmodule

// File: rtl/sdram_pd_fsm.sv
module sdram_pd_fsm
    import sdram_pd_pkg::*;
#(
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_en,
    input  logic              clk_off_q,
    input  logic              clk_off_nxt,
    input  logic              mode_ddr,
    input  logic              req_valid,
    input  logic              if_busy,
    input  logic [WAKE_W-1:0] wake_lat,
    input  logic              wake_last,
    output logic              wake_load,
    output logic              wake_run,
    output pd_state_e         state_q,
    output pd_out_t           outs
);
    pd_state_e state_d;
    logic      save_any;
    logic      idle;
    logic      slow_wake;

    assign save_any  = pd_en | clk_off_nxt;
    assign idle      = ~if_busy & ~req_valid;
    assign slow_wake = mode_ddr & (wake_lat != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        wake_load = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                if (idle && save_any) begin
                    state_d = ST_PWRDN;                 // enter
                end
            end
            ST_PWRDN: begin
                if (req_valid) begin
                    if (slow_wake) begin
                        state_d   = ST_WAKE;            // ddr_wake
                        wake_load = 1'b1;
                    end else begin
                        state_d = ST_ACTIVE;            // fast_exit
                    end
                end else if (if_busy || !save_any) begin
                    state_d = ST_ACTIVE;                // fast_exit
                end
            end
            ST_WAKE: begin
                if (wake_last) begin
                    state_d = ST_ACTIVE;                // release
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    assign wake_run = (state_q == ST_WAKE);

    // Outputs
    always_comb begin
        outs = '{cke: 1'b1, clk_en: 1'b1, stall: 1'b0};
        unique case (state_q)
            ST_ACTIVE: ;
            ST_PWRDN: begin
                outs.cke    = ~pd_en;
                outs.clk_en = ~clk_off_q;
                outs.stall  = req_valid;
            end
            ST_WAKE: begin
                outs.stall  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
    import sdram_pd_pkg::*;
#(
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pd_en,
    input  logic              cfg_clk_off,
    input  logic              mode_ddr,
    input  logic              req_valid,
    input  logic              if_busy,
    input  logic [WAKE_W-1:0] wake_lat,
    output logic              cke,
    output logic              ext_clk_en,
    output logic              req_stall
);
    logic      clk_off_q;
    logic      clk_off_nxt;
    logic      wake_load;
    logic      wake_run;
    logic      wake_last;
    pd_state_e state_q;
    pd_out_t   outs;

    sdram_pd_cfg_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .if_busy     (if_busy),
        .clk_off_in  (cfg_clk_off),
        .clk_off_q   (clk_off_q),
        .clk_off_nxt (clk_off_nxt)
    );

    sdram_pd_wake_cnt #(.WAKE_W(WAKE_W)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_load),
        .load_val (wake_lat),
        .run      (wake_run),
        .last     (wake_last)
    );

    sdram_pd_fsm #(.WAKE_W(WAKE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_en       (cfg_pd_en),
        .clk_off_q   (clk_off_q),
        .clk_off_nxt (clk_off_nxt),
        .mode_ddr    (mode_ddr),
        .req_valid   (req_valid),
        .if_busy     (if_busy),
        .wake_lat    (wake_lat),
        .wake_last   (wake_last),
        .wake_load   (wake_load),
        .wake_run    (wake_run),
        .state_q     (state_q),
        .outs        (outs)
    );

    assign cke        = outs.cke;
    assign ext_clk_en = outs.clk_en;
    assign req_stall  = outs.stall;
endmodule

// File: rtl/sdram_pd_ctrl_chk.sv
module sdram_pd_ctrl_chk
    import sdram_pd_pkg::*;
#(
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pd_en,
    input  logic              mode_ddr,
    input  logic              req_valid,
    input  logic              if_busy,
    input  logic [WAKE_W-1:0] wake_lat,
    input  logic              cke,
    input  logic              ext_clk_en,
    input  logic              req_stall,
    input  pd_state_e         state_q,
    input  logic              clk_off_q
);
    // R2: CKE is lowered only in power-down with the enable set
    p_cke_low_pd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cfg_pd_en && state_q == ST_PWRDN));

    // R4: the external clock is stopped only in power-down with the setting applied
    p_clk_off_pd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_clk_en |-> (clk_off_q && state_q == ST_PWRDN));

    // R6: busy outside the wake delay forces the active state next
    p_busy_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_busy && !req_valid && state_q != ST_WAKE) |=> (state_q == ST_ACTIVE));

    // R7: SDR releases in the cycle after the request
    p_sdr_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWRDN && req_valid && !mode_ddr) |=> (!req_stall && cke && ext_clk_en));

    // R8: DDR with a nonzero delay keeps the stall with the memory awake
    p_ddr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWRDN && req_valid && mode_ddr && wake_lat != '0) |=> (req_stall && cke && ext_clk_en));

    // R9: the applied clock-disable value holds while busy
    p_clk_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        if_busy |=> $stable(clk_off_q));

    // R10: no stall while active
    p_active_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |-> !req_stall);
endmodule

bind sdram_pd_ctrl sdram_pd_ctrl_chk #(.WAKE_W(WAKE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_pd_en  (cfg_pd_en),
    .mode_ddr   (mode_ddr),
    .req_valid  (req_valid),
    .if_busy    (if_busy),
    .wake_lat   (wake_lat),
    .cke        (cke),
    .ext_clk_en (ext_clk_en),
    .req_stall  (req_stall),
    .state_q    (state_q),
    .clk_off_q  (clk_off_q)
);

// File: tb/sdram_pd_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_pd_ctrl_tb;
    localparam int WAKE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_pd_en = 1'b0;
    logic              cfg_clk_off = 1'b0;
    logic              mode_ddr = 1'b0;
    logic              req_valid = 1'b0;
    logic              if_busy = 1'b0;
    logic [WAKE_W-1:0] wake_lat = '0;
    logic              cke;
    logic              ext_clk_en;
    logic              req_stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_pd_ctrl #(.WAKE_W(WAKE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .cfg_clk_off(cfg_clk_off),
        .mode_ddr(mode_ddr), .req_valid(req_valid), .if_busy(if_busy), .wake_lat(wake_lat),
        .cke(cke), .ext_clk_en(ext_clk_en), .req_stall(req_stall)
    );

    // compare {cke, ext_clk_en, req_stall} 1 ns after the falling edge
    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        #1;
        act = {cke, ext_clk_en, req_stall};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {cke,clk_en,stall} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic busy, input logic req);
        @(negedge clk);
        if_busy   = busy;
        req_valid = req;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 in reset", 3'b110);
        end
        @(negedge clk);
        rst_n = 1'b1;
        if_busy = 1'b1;
        chk("R1 after reset", 3'b110);

        // Sweep of enables, mode and wake latency: R2 R3 R4 R5 R7 R8 R10
        for (int pd = 0; pd < 2; pd++) begin
            for (int ck = 0; ck < 2; ck++) begin
                for (int md = 0; md < 2; md++) begin
                    for (int lat = 0; lat < 5; lat++) begin
                        logic       pde;
                        logic [2:0] pdv;
                        logic       slow;
                        pde  = (pd != 0) || (ck != 0);
                        pdv  = {1'(pd == 0), 1'(ck == 0), 1'b0};
                        slow = pde && (md != 0) && (lat != 0);
                        // A: busy, new configuration
                        @(negedge clk);
                        if_busy = 1'b1; req_valid = 1'b0;
                        cfg_pd_en = 1'(pd); cfg_clk_off = 1'(ck);
                        mode_ddr = 1'(md); wake_lat = WAKE_W'(lat);
                        chk("R10 busy active", 3'b110);
                        // B: first idle cycle, still active
                        cyc(1'b0, 1'b0);
                        chk("R2 idle entry cycle", 3'b110);
                        // C, D: power-down if any saving enabled
                        repeat (2) begin
                            cyc(1'b0, 1'b0);
                            if (pde) chk(ck != 0 ? "R4 power-down" : "R3 power-down", pdv);
                            else     chk("R5 no power-down", 3'b110);
                        end
                        // E: request arrives
                        cyc(1'b0, 1'b1);
                        if (pde) chk("R7 stall on request", pdv | 3'b001);
                        else     chk("R5 no stall", 3'b110);
                        // DDR wake delay
                        if (slow) begin
                            for (int k = 0; k < lat; k++) begin
                                @(negedge clk);
                                chk("R8 wake delay", 3'b111);
                            end
                        end
                        @(negedge clk);
                        chk(slow ? "R8 release" : "R7 release", 3'b110);
                        // cleanup
                        cyc(1'b1, 1'b0);
                        chk("R10 cleanup", 3'b110);
                    end
                end
            end
        end

        // R6: busy during power-down
        @(negedge clk);
        cfg_pd_en = 1'b1; cfg_clk_off = 1'b0; mode_ddr = 1'b0; wake_lat = '0;
        if_busy = 1'b1; req_valid = 1'b0;
        chk("R6 busy no entry", 3'b110);
        cyc(1'b1, 1'b0);
        chk("R6 busy no entry", 3'b110);
        cyc(1'b0, 1'b0);
        chk("R6 idle", 3'b110);
        cyc(1'b0, 1'b0);
        chk("R6 powered down", 3'b010);
        cyc(1'b1, 1'b0);
        chk("R6 busy seen", 3'b010);
        @(negedge clk);
        chk("R6 woken by busy", 3'b110);

        // R9: clock-disable value only taken on idle cycles
        @(negedge clk);
        cfg_pd_en = 1'b1; cfg_clk_off = 1'b1;
        chk("R9 busy set", 3'b110);
        @(negedge clk);
        cfg_clk_off = 1'b0;
        chk("R9 busy cleared", 3'b110);
        cyc(1'b0, 1'b0);
        chk("R9 first idle", 3'b110);
        cyc(1'b0, 1'b0);
        chk("R9 busy-only value ignored", 3'b010);
        cyc(1'b1, 1'b0);
        cfg_clk_off = 1'b1;
        chk("R9 busy again", 3'b010);
        @(negedge clk);
        chk("R9 active", 3'b110);
        cyc(1'b0, 1'b0);
        chk("R9 idle applies", 3'b110);
        cyc(1'b0, 1'b0);
        chk("R9 idle value governs", 3'b000);
        cyc(1'b0, 1'b0);
        cfg_pd_en = 1'b0;
        chk("R4 clock only", 3'b100);
        cyc(1'b1, 1'b0);
        cfg_clk_off = 1'b0;
        chk("R6 busy from clock-only", 3'b100);
        @(negedge clk);
        chk("R6 back active", 3'b110);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule